// File: doc/BRIEF.md
# Socket Command and Interrupt Unit

This block holds the control-side registers of an eight-socket network controller. A host writes bytes into a 10-bit register space. The lower half holds the global registers. The upper half is split into one 64-byte window per socket. Writing a command code to a socket's command byte starts a one-shot action. The action can move the socket's status byte to an open-for-stream, open-for-datagram or closed code, chosen from the protocol nibble of that socket's mode byte. It can also ask the transmit path to drain that socket's queue. The command byte itself never holds a value.

Interrupt state sits in two global bytes and in one byte per socket. Internal event inputs set the bits. The host clears a bit by writing a 1 to it. Two global mask bytes gate the global interrupt bytes onto a single registered, level-sensitive interrupt output. Only the upper nibble of the first global interrupt byte takes part in that output.

Reads are combinational from `rd_addr`. Writes take effect at the clock edge on which `wr_en` is high. `drain_req` is a one-cycle control pulse with no handshake, because the drain always completes downstream.

Top module: `sockirq_unit`

## Requirements
- R1: Addresses with bit 9 set select socket number `addr[8:6]`, at offset `addr[5:0]`. Writes to one socket leave every other socket unchanged. Unmapped addresses read 0x00.
- R2: Offset 0x03 (command) always reads 0x00, including after any write. Offset 0x02 reads 0x00 and ignores writes. Offsets 0x08 and 0x09 (status) ignore host writes.
- R3: Command 0x01 (open) sets status to 0x13 when bits 3:0 of the mode byte at offset 0x01 equal 1. It sets status to 0x22 when they equal 2, and to 0x00 for any other value. Offsets 0x00 and 0x01 read back what was written.
- R4: Command 0x10 (close) sets status to 0x00. Every code other than 0x01, 0x10 and 0x20 leaves status unchanged.
- R5: Command 0x20 (send) written while status is 0x22 raises `drain_req[s]` for exactly the one cycle after the write edge. Otherwise no drain request is made.
- R6: Global interrupt bytes IR0 (address 0x002) and IR1 (address 0x003), and the socket interrupt byte (offset 0x07), clear each bit written as 1. Offset 0x06 reads 0x00.
- R7: `evt_gir_set[15:8]` sets IR0 bits and `evt_gir_set[7:0]` sets IR1 bits. `evt_sock_set[8*s+7:8*s]` sets socket s interrupt bits. A set wins over a host clear of the same bit in the same cycle.
- R8: Mask bytes IMR0 (0x004) and IMR1 (0x005) are read/write. The interrupt is active when ((IR0 & IMR0 & 0xF0) | (IR1 & IMR1)) is nonzero.
- R9: `irq_o` is registered. It follows a change in IR or IMR one clock after that register changes.
- R10: Offsets 0x12 and 0x13 are write-only and read 0xFF. Addresses 0x0FE and 0x0FF are read-only and read 0x53 and 0x00.
- R11: In the write-size bytes, offset 0x21 keeps only bit 0, offset 0x20 reads 0x00 and ignores writes, and offsets 0x22 and 0x23 keep all 8 bits.
- R12: After reset all registers read 0x00 except the identification bytes, and `irq_o` and `drain_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 10 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 10 | Read address |
| rd_data | output | 8 | Combinational read data |
| evt_gir_set | input | 16 | Global interrupt set bits (IR0 in 15:8, IR1 in 7:0) |
| evt_sock_set | input | 64 | Per-socket interrupt set bits, 8 per socket |
| drain_req | output | 8 | One-cycle transmit drain request per socket |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The hardest case to reach is an event set and a host clear landing on the same interrupt bit in the same clock. The bench drives the event input and the write strobe from one task, on the same falling edge, so both are sampled at a single rising edge. It then reads the register back. The one-cycle lag of `irq_o` is checked by sampling it once right after the write edge, when it must still be unchanged, and again one clock later.

// File: rtl/sockirq_pkg.sv
package sockirq_pkg;
  localparam logic [7:0] CMD_OPEN  = 8'h01;
  localparam logic [7:0] CMD_CLOSE = 8'h10;
  localparam logic [7:0] CMD_SEND  = 8'h20;

  localparam logic [7:0] ST_CLOSED = 8'h00;
  localparam logic [7:0] ST_STREAM = 8'h13;
  localparam logic [7:0] ST_DGRAM  = 8'h22;

  localparam logic [7:0] ID_HI = 8'h53;
  localparam logic [7:0] ID_LO = 8'h00;

  localparam logic [5:0] OFS_MODE0  = 6'h00;
  localparam logic [5:0] OFS_MODE1  = 6'h01;
  localparam logic [5:0] OFS_CMD    = 6'h03;
  localparam logic [5:0] OFS_SIR    = 6'h07;
  localparam logic [5:0] OFS_STAT   = 6'h09;
  localparam logic [5:0] OFS_DPRT0  = 6'h12;
  localparam logic [5:0] OFS_DPRT1  = 6'h13;
  localparam logic [5:0] OFS_WSZ1   = 6'h21;
  localparam logic [5:0] OFS_WSZ2   = 6'h22;
  localparam logic [5:0] OFS_WSZ3   = 6'h23;

  function automatic logic [7:0] open_status(input logic [3:0] proto);
    case (proto)
      4'd1:    open_status = ST_STREAM;
      4'd2:    open_status = ST_DGRAM;
      default: open_status = ST_CLOSED;
    endcase
  endfunction
endpackage

// File: rtl/sock_slot.sv
module sock_slot
  import sockirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [5:0] wr_off,
  input  logic [7:0] wr_data,
  input  logic [5:0] rd_off,
  input  logic [7:0] evt_set,
  output logic [7:0] rd_data,
  output logic       drain_req
);
  logic [7:0] mode0_q, mode1_q, stat_q, sir_q, wsz2_q, wsz3_q;
  logic       wsz1_q, drain_q;
  logic [7:0] sir_clr;

  assign sir_clr = (wr_en && wr_off == OFS_SIR) ? wr_data : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode0_q <= '0; mode1_q <= '0; stat_q <= ST_CLOSED; sir_q <= '0;
      wsz1_q  <= 1'b0; wsz2_q <= '0; wsz3_q <= '0; drain_q <= 1'b0;
    end else begin
      drain_q <= 1'b0;
      sir_q   <= (sir_q & ~sir_clr) | evt_set;
      if (wr_en) begin
        case (wr_off)
          OFS_MODE0: mode0_q <= wr_data;
          OFS_MODE1: mode1_q <= wr_data;
          OFS_WSZ1:  wsz1_q  <= wr_data[0];
          OFS_WSZ2:  wsz2_q  <= wr_data;
          OFS_WSZ3:  wsz3_q  <= wr_data;
          OFS_CMD: begin
            case (wr_data)
              CMD_OPEN:  stat_q  <= open_status(mode1_q[3:0]);
              CMD_CLOSE: stat_q  <= ST_CLOSED;
              CMD_SEND:  drain_q <= (stat_q == ST_DGRAM);
              default:   ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_off)
      OFS_MODE0:            rd_data = mode0_q;
      OFS_MODE1:            rd_data = mode1_q;
      OFS_SIR:              rd_data = sir_q;
      OFS_STAT:             rd_data = stat_q;
      OFS_DPRT0, OFS_DPRT1: rd_data = 8'hFF;
      OFS_WSZ1:             rd_data = {7'b0, wsz1_q};
      OFS_WSZ2:             rd_data = wsz2_q;
      OFS_WSZ3:             rd_data = wsz3_q;
      default:              rd_data = 8'h00;
    endcase
  end

  assign drain_req = drain_q;
endmodule

// File: rtl/glob_irq.sv
module glob_irq
  import sockirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [8:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [8:0]  rd_addr,
  input  logic [15:0] evt_set,
  output logic [7:0]  rd_data,
  output logic [15:0] ir_q,
  output logic [15:0] imr_q,
  output logic        irq
);
  logic [7:0] ir0_q, ir1_q, imr0_q, imr1_q;
  logic [7:0] clr0, clr1;
  logic       irq_q;

  assign clr0 = (wr_en && wr_addr == 9'h002) ? wr_data : 8'h00;
  assign clr1 = (wr_en && wr_addr == 9'h003) ? wr_data : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir0_q <= '0; ir1_q <= '0; imr0_q <= '0; imr1_q <= '0; irq_q <= 1'b0;
    end else begin
      ir0_q <= (ir0_q & ~clr0) | evt_set[15:8];
      ir1_q <= (ir1_q & ~clr1) | evt_set[7:0];
      if (wr_en && wr_addr == 9'h004) imr0_q <= wr_data;
      if (wr_en && wr_addr == 9'h005) imr1_q <= wr_data;
      irq_q <= |((ir0_q & imr0_q & 8'hF0) | (ir1_q & imr1_q));
    end
  end

  always_comb begin
    case (rd_addr)
      9'h002:  rd_data = ir0_q;
      9'h003:  rd_data = ir1_q;
      9'h004:  rd_data = imr0_q;
      9'h005:  rd_data = imr1_q;
      9'h0FE:  rd_data = ID_HI;
      9'h0FF:  rd_data = ID_LO;
      default: rd_data = 8'h00;
    endcase
  end

  assign ir_q  = {ir0_q, ir1_q};
  assign imr_q = {imr0_q, imr1_q};
  assign irq   = irq_q;
endmodule

// File: rtl/sockirq_unit.sv
module sockirq_unit #(
  parameter int NSOCK = 8,
  parameter int AW    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [7:0]         rd_data,
  input  logic [15:0]        evt_gir_set,
  input  logic [NSOCK*8-1:0] evt_sock_set,
  output logic [NSOCK-1:0]   drain_req,
  output logic               irq_o
);
  localparam int SW  = $clog2(NSOCK);
  localparam int WIN = AW - 1;

  logic [7:0]  sock_rd [NSOCK];
  logic [7:0]  glob_rd;
  logic [15:0] ir_q, imr_q;

  glob_irq u_glob (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && !wr_addr[WIN]), .wr_addr(wr_addr[WIN-1:0]), .wr_data(wr_data),
    .rd_addr(rd_addr[WIN-1:0]), .evt_set(evt_gir_set),
    .rd_data(glob_rd), .ir_q(ir_q), .imr_q(imr_q), .irq(irq_o)
  );

  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    logic sel;
    assign sel = wr_en && wr_addr[WIN] && (wr_addr[WIN-1 -: SW] == SW'(s));
    sock_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(sel), .wr_off(wr_addr[5:0]), .wr_data(wr_data),
      .rd_off(rd_addr[5:0]), .evt_set(evt_sock_set[8*s +: 8]),
      .rd_data(sock_rd[s]), .drain_req(drain_req[s])
    );
  end

  assign rd_data = rd_addr[WIN] ? sock_rd[rd_addr[WIN-1 -: SW]] : glob_rd;
endmodule

// File: rtl/sockirq_chk.sv
module sockirq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [9:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic [9:0]  rd_addr,
  input logic [7:0]  rd_data,
  input logic [15:0] evt_gir_set,
  input logic [7:0]  drain_req,
  input logic        irq_o,
  input logic [15:0] ir_q,
  input logic [15:0] imr_q
);
  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == 10'h0FE |-> rd_data == 8'h53); // R10
  AST_DPORT_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[9] && (rd_addr[5:0] == 6'h12 || rd_addr[5:0] == 6'h13)) |-> rd_data == 8'hFF); // R10
  AST_CMD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[9] && rd_addr[5:0] == 6'h03) |-> rd_data == 8'h00); // R2
  AST_DRAIN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|drain_req) |-> $past(wr_en && wr_addr[9] && wr_addr[5:0] == 6'h03 && wr_data == 8'h20)); // R5
  AST_DRAIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drain_req)); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_gir_set != 16'h0 |=> (ir_q & $past(evt_gir_set)) == $past(evt_gir_set)); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_q[7:0] == 8'h0 && imr_q[15:12] == 4'h0) |=> !irq_o); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(ir_q) && $stable(imr_q)) |=> $stable(irq_o)); // R9
endmodule

bind sockirq_unit sockirq_chk u_chk (.*);

// File: tb/tb_sockirq_unit.sv
module tb_sockirq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [9:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [15:0] evt_gir_set = '0;
  logic [63:0] evt_sock_set = '0;
  logic [7:0]  drain_req;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sockirq_unit dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [7:0] exp);
    rd_addr = a;
    #0.5;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset;
    rd_chk("R12", 10'h0FE, 8'h53);
    rd_chk("R12", 10'h0FF, 8'h00);
    rd_chk("R12", 10'h002, 8'h00);
    rd_chk("R12", 10'h209, 8'h00);
    chk("R12", {7'b0, irq_o}, 8'h00);
    chk("R12", drain_req, 8'h00);
  endtask

  task automatic t_open;
    wr(10'h2C1, 8'h01); wr(10'h2C3, 8'h01);
    rd_chk("R3", 10'h2C9, 8'h13);
    rd_chk("R2", 10'h2C3, 8'h00);
    rd_chk("R3", 10'h2C1, 8'h01);
    rd_chk("R1", 10'h309, 8'h00);
    wr(10'h2C1, 8'h42); wr(10'h2C3, 8'h01);
    rd_chk("R3", 10'h2C9, 8'h22);
    wr(10'h2C9, 8'hFF); wr(10'h2C8, 8'hFF); wr(10'h2C2, 8'h77);
    rd_chk("R2", 10'h2C9, 8'h22);
    rd_chk("R2", 10'h2C2, 8'h00);
    wr(10'h2C1, 8'h05); wr(10'h2C3, 8'h01);
    rd_chk("R3", 10'h2C9, 8'h00);
  endtask

  task automatic t_close_other;
    wr(10'h341, 8'h02); wr(10'h343, 8'h01);
    wr(10'h343, 8'h40);
    rd_chk("R4", 10'h349, 8'h22);
    wr(10'h343, 8'h10);
    rd_chk("R4", 10'h349, 8'h00);
  endtask

  task automatic t_send;
    wr(10'h341, 8'h02); wr(10'h343, 8'h01);
    wr(10'h343, 8'h20);
    chk("R5", drain_req, 8'h20);
    @(negedge clk);
    chk("R5", drain_req, 8'h00);
    wr(10'h241, 8'h01); wr(10'h243, 8'h01);
    wr(10'h243, 8'h20);
    chk("R5", drain_req, 8'h00);
  endtask

  task automatic t_gir;
    @(negedge clk); evt_gir_set = 16'hA53C;
    @(negedge clk); evt_gir_set = 16'h0;
    rd_chk("R7", 10'h002, 8'hA5);
    rd_chk("R7", 10'h003, 8'h3C);
    wr(10'h002, 8'h81);
    rd_chk("R6", 10'h002, 8'h24);
    chk("R8", {7'b0, irq_o}, 8'h00);
    wr(10'h005, 8'h04);
    rd_chk("R8", 10'h005, 8'h04);
    chk("R9", {7'b0, irq_o}, 8'h00);
    @(negedge clk);
    chk("R9", {7'b0, irq_o}, 8'h01);
    wr(10'h005, 8'h00); @(negedge clk);
    chk("R8", {7'b0, irq_o}, 8'h00);
    wr(10'h004, 8'h0F); @(negedge clk);
    chk("R8", {7'b0, irq_o}, 8'h00);
    wr(10'h004, 8'h20); @(negedge clk);
    chk("R8", {7'b0, irq_o}, 8'h01);
    wr(10'h002, 8'h20);
    chk("R9", {7'b0, irq_o}, 8'h01);
    @(negedge clk);
    chk("R6", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_setwins;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 10'h003; wr_data = 8'hFF; evt_gir_set = 16'h0001;
    @(negedge clk);
    wr_en = 1'b0; evt_gir_set = 16'h0;
    rd_chk("R7", 10'h003, 8'h01);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 10'h287; wr_data = 8'hFF; evt_sock_set = 64'h0000_0000_0003_0000;
    @(negedge clk);
    wr_en = 1'b0; evt_sock_set = '0;
    rd_chk("R7", 10'h287, 8'h03);
    rd_chk("R1", 10'h247, 8'h00);
    wr(10'h287, 8'h01);
    rd_chk("R6", 10'h287, 8'h02);
    wr(10'h286, 8'hFF);
    rd_chk("R6", 10'h286, 8'h00);
  endtask

  task automatic t_misc;
    wr(10'h212, 8'h12);
    rd_chk("R10", 10'h212, 8'hFF);
    rd_chk("R10", 10'h213, 8'hFF);
    wr(10'h0FE, 8'h00); wr(10'h0FF, 8'hAA);
    rd_chk("R10", 10'h0FE, 8'h53);
    rd_chk("R10", 10'h0FF, 8'h00);
    wr(10'h221, 8'hFF); wr(10'h220, 8'hFF); wr(10'h222, 8'hAB);
    rd_chk("R11", 10'h221, 8'h01);
    rd_chk("R11", 10'h220, 8'h00);
    rd_chk("R11", 10'h222, 8'hAB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_open();
    t_close_other();
    t_send();
    t_gir();
    t_setwins();
    t_misc();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule